// File: doc/BRIEF.md
# Two-Stage UART Baud Tick Generator

This block derives the 16x oversampling enable for a UART transmitter and receiver from the system clock. It uses two dividers in series. The first is a coarse prescaler whose ratio comes from a 5-bit code. The second is an 11-bit programmable divisor that counts its programmed value plus one. Each time the second stage wraps, the block emits a one-cycle `tick`. The shifters treat that tick as their sample and shift enable.

Software programs the chain through a byte-wide write port that holds two registers. The configuration register carries the prescaler code together with divisor bits 10..8. The divisor-low register carries divisor bits 7..0. Reset clears the configuration register but leaves the divisor-low byte untouched. Each counter picks up new register values only when it reaches terminal count, so a write never produces a truncated or stretched interval. The `en` input gates the whole chain, and dropping it restarts both stages.

Top module: `uart_tick_gen`

## Requirements
- R1: While `rst_n` is low and right after it rises, `tick` is 0; reset clears the prescaler code and divisor bits 10..8 to 0, so an enabled chain without a configuration write produces no ticks.
- R2: The divisor-low byte keeps its value through reset; after reset only a configuration write is needed for the old low byte to take effect again.
- R3: A write with `wr_en`=1 and `wr_sel`=0 loads the configuration register: `wr_data[4:0]` is the prescaler code and `wr_data[7:5]` is divisor bits 10..8; `wr_sel`=1 loads divisor bits 7..0 from `wr_data`; with `wr_en`=0 neither register changes.
- R4: A prescaler code of 0 stops the chain: no tick occurs while it is selected.
- R5: With prescaler code N (1..31) and divisor D, successive ticks are N*(D+1) system-clock cycles apart.
- R6: Each tick is high for exactly one cycle whenever N*(D+1) is at least 2; for N=1, D=0 `tick` stays high every cycle.
- R7: In the first cycle `en` is sampled high with a nonzero code, both stages are at terminal count, so `tick` is high right after that clock edge.
- R8: While `en` is low no tick occurs and both counters return to their start state; re-enabling repeats the R7 timing.
- R9: A divisor write made during an interval does not alter that interval; the interval after the next tick uses the new value.
- R10: The full divisor range works, including D=2047 (2048 prescaler periods) and values that cross the byte boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| en | input | 1 | Enables the divider chain; low holds both counters at their start state |
| wr_en | input | 1 | Register write strobe, one write per cycle it is high |
| wr_sel | input | 1 | Register select: 0 = configuration (code, divisor high), 1 = divisor low byte |
| wr_data | input | 8 | Write data |
| tick | output | 1 | 16x oversample enable, one system-clock cycle wide |

## Verification
The in-design assertions check the cycle-local rules on every clock. They confirm that register writes land in the selected register and that idle cycles leave all registers unchanged. They also confirm that a zero code or a low enable suppresses the next tick, that every tick follows a prescaler step, and that a tick with a nonzero divisor is followed by a low cycle. Several behaviours span many cycles and can only be shown by the bench scenarios. These are the exact N*(D+1) spacing over the whole code and divisor range, the survival of the low byte across reset, the first-tick timing after enabling, and the completion of an interval at its old length after a write made in the middle of it.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;

  typedef enum logic {
    SEL_CFG   = 1'b0,
    SEL_DIVLO = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/utg_regs.sv
module utg_regs
  import uart_tick_pkg::*;
#(
  parameter int PSC_W  = 5,
  parameter int DIV_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PSC_W-1:0]  psc_code,
  output logic [DIV_W-1:0]  divisor
);

  localparam int DIV_HI_W = DIV_W - DATA_W;

  logic [PSC_W-1:0]    code_q, code_d;
  logic [DIV_HI_W-1:0] dhi_q, dhi_d;
  logic [DATA_W-1:0]   dlo_q;
  logic                cfg_we, lo_we;

  always_comb begin
    cfg_we = wr_en && (reg_sel_e'(wr_sel) == SEL_CFG);
    lo_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_DIVLO);
    code_d = code_q;
    dhi_d  = dhi_q;
    if (cfg_we) begin
      code_d = wr_data[PSC_W-1:0];
      dhi_d  = wr_data[DATA_W-1 -: DIV_HI_W];
    end
  end

  // configuration register: cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      dhi_q  <= '0;
    end else begin
      code_q <= code_d;
      dhi_q  <= dhi_d;
    end
  end

  // divisor low byte: deliberately not reset, clock-enabled on its write
  always_ff @(posedge clk) begin
    if (lo_we) dlo_q <= wr_data;
  end

  assign psc_code = code_q;
  assign divisor  = {dhi_q, dlo_q};

  p_cfg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> ({dhi_q, code_q} == $past(wr_data)));

  p_lo_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (dlo_q == $past(wr_data)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(code_q) && $stable(dhi_q) && $stable(dlo_q)));

endmodule

// File: rtl/utg_prescale.sv
module utg_prescale #(
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] code,
  output logic             stage_tick
);

  logic [PSC_W-1:0] cnt_q, cnt_d;
  logic             active;

  always_comb begin
    active     = run && (code != '0);
    stage_tick = active && (cnt_q == '0);
    cnt_d      = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (active) begin
      if (cnt_q == '0) cnt_d = code - 1'b1;  // reload only at terminal count
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_step_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_tick && (code > 1)) |=> !stage_tick);

endmodule

// File: rtl/utg_divide.sv
module utg_divide #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             at_term;

  always_comb begin
    at_term = (cnt_q == '0);
    tick_d  = run && step && at_term;
    cnt_d   = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (step) begin
      if (at_term) cnt_d = divisor;          // reload only at terminal count
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  p_tick_after_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(step));

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ($past(divisor) != '0)) |=> !tick_o);

endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int PSC_W  = 5,
  parameter int DIV_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tick
);

  logic [PSC_W-1:0] psc_code;
  logic [DIV_W-1:0] divisor;
  logic             psc_step;

  utg_regs #(.PSC_W(PSC_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .psc_code (psc_code),
    .divisor  (divisor)
  );

  utg_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (en),
    .code       (psc_code),
    .stage_tick (psc_step)
  );

  utg_divide #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .step    (psc_step),
    .divisor (divisor),
    .tick_o  (tick)
  );

  p_code_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_code == '0) |=> !tick);

  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

endmodule

// File: tb/sim_uart_tick_gen.sv
module sim_uart_tick_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tick;

  int nvec = 0;
  int nbad = 0;
  int cyc  = 0;

  localparam int LIM = 70000;

  uart_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .tick(tick)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      nbad = nbad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  function automatic int period(input int code, input int div);
    return code * (div + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] data);
    wr_sel = sel; wr_data = data; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input logic [4:0] code, input logic [10:0] div);
    wr(1'b0, {div[10:8], code});
    wr(1'b1, div[7:0]);
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!tick && n < LIM);
  endtask

  // en has just been raised at a negedge
  task automatic measure(input int per, input int nint, input string req);
    int n;
    wait_tick(n);
    chk(n == 1, "R7", n, 1);
    @(negedge clk);
    chk(tick == (per == 1), "R6", int'(tick), int'(per == 1));
    n = 1;
    while (!tick && n < LIM) begin
      @(negedge clk); n++;
    end
    chk(n == per, req, n, per);
    for (int i = 1; i < nint; i++) begin
      wait_tick(n);
      chk(n == per, req, n, per);
    end
  endtask

  task automatic run_cfg(input int code, input int div, input int nint, input string req);
    en = 1'b0;
    cfg(code[4:0], div[10:0]);
    en = 1'b1;
    measure(period(code, div), nint, req);
    en = 1'b0;
  endtask

  task automatic count_ticks(input int ncyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
  endtask

  initial begin
    int n, cnt, code, div;
    void'($urandom(32'h1234_5eed));

    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R1", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tick == 1'b0, "R1", int'(tick), 0);

    // R1: reset-cleared code means no ticks even when enabled
    wr(1'b1, 8'd0);
    en = 1'b1;
    count_ticks(64, cnt);
    chk(cnt == 0, "R1", cnt, 0);
    en = 1'b0;

    // R4: code 0 with a divisor programmed
    cfg(5'd0, 11'd3);
    en = 1'b1;
    count_ticks(100, cnt);
    chk(cnt == 0, "R4", cnt, 0);
    en = 1'b0;

    // R5 / R6 directed corners
    run_cfg(1, 0, 4, "R6");
    run_cfg(1, 1, 4, "R5");
    run_cfg(31, 0, 3, "R5");
    run_cfg(31, 3, 3, "R5");
    run_cfg(3, 7, 3, "R5");

    // R10 / R3: byte-boundary and full range divisors
    run_cfg(1, 256, 3, "R10");
    run_cfg(2, 255, 2, "R10");
    run_cfg(1, 2047, 3, "R10");
    run_cfg(1, 1280, 2, "R3");

    // R3: idle cycles with wr_en low and changing data leave config alone
    en = 1'b0;
    cfg(5'd2, 11'd2);
    wr_sel = 1'b0; wr_data = 8'hFF;
    repeat (5) @(negedge clk);
    wr_sel = 1'b1; wr_data = 8'hAA;
    repeat (5) @(negedge clk);
    en = 1'b1;
    measure(6, 2, "R3");
    en = 1'b0;

    // R8: disable mid-run, then re-enable
    cfg(5'd2, 11'd1);
    en = 1'b1;
    measure(4, 2, "R5");
    en = 1'b0;
    count_ticks(40, cnt);
    chk(cnt == 0, "R8", cnt, 0);
    en = 1'b1;
    wait_tick(n);
    chk(n == 1, "R8", n, 1);
    wait_tick(n);
    chk(n == 4, "R8", n, 4);
    en = 1'b0;

    // R9: divisor write mid-interval
    @(negedge clk);
    cfg(5'd2, 11'd5);
    en = 1'b1;
    wait_tick(n);
    wr_sel = 1'b1; wr_data = 8'd2; wr_en = 1'b1;
    n = 0;
    do begin
      @(negedge clk); wr_en = 1'b0; n++;
    end while (!tick && n < LIM);
    chk(n == 12, "R9", n, 12);
    wait_tick(n);
    chk(n == 6, "R9", n, 6);
    en = 1'b0;

    // R2: low byte survives reset
    @(negedge clk);
    cfg(5'd1, 11'd7);
    rst_n = 1'b0;
    @(negedge clk);
    chk(tick == 1'b0, "R1", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(1'b0, 8'h01);
    en = 1'b1;
    measure(8, 2, "R2");
    en = 1'b0;

    // R5: constrained random small divisors
    for (int k = 0; k < 20; k++) begin
      code = 1 + int'($urandom % 31);
      div  = int'($urandom % 16);
      @(negedge clk);
      run_cfg(code, div, 3, "R5");
    end
    // R10: random wide divisors with code 1
    for (int k = 0; k < 3; k++) begin
      div = int'($urandom % 2048);
      @(negedge clk);
      run_cfg(1, div, 2, "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule